// File: doc/BRIEF.md
# Register ALU with Flag Register

This block executes the register-to-register arithmetic and logic group of a small 8-bit interpreter core. It also executes the load-immediate and add-immediate operations. It holds its own file of sixteen 8-bit registers. The highest register, index 15 (written vF here), serves both as an ordinary register and as the flag register. A caller presents an operation class, a 4-bit sub-operation code, two register indices x and y and an immediate byte. The block reads vX and vY, computes the result and writes vX and vF in a single commit. A combinational debug port reads any register at any time.

Each operation passes through three named states. ST_IDLE accepts an operation when `op_valid` is high and moves to ST_FETCH. ST_FETCH captures the two operands and always moves to ST_COMMIT. ST_COMMIT writes the register file, raises `op_done` for one cycle and always returns to ST_IDLE. `op_ready` is high only in ST_IDLE. A request made while the block is busy is dropped.

The flag is written after the result. When the destination is vF, only the flag is kept. Subtraction stores the inverted borrow, so a value of 1 means that no borrow occurred. When x equals y, both operands come from the same register.

Top module: `reg_alu_core`

## Requirements
- R1: After reset all sixteen registers read 0x00, `op_ready` is 1, and `op_done` and `op_illegal` are 0.
- R2: With class 0 (register-register), the sub-operation selects what vX receives. Sub-op 0x0 loads vY. Sub-ops 0x1, 0x2 and 0x3 load vX OR vY, vX AND vY and vX XOR vY. vF is unchanged unless x is 15.
- R3: Sub-op 0x4 writes the low 8 bits of vX+vY into vX and the carry-out (0 or 1) into vF.
- R4: Sub-op 0x5 writes vX−vY (mod 256) into vX. It writes vF=1 when vX ≥ vY (no borrow) and vF=0 otherwise.
- R5: Sub-op 0x7 writes vY−vX (mod 256) into vX. It writes vF=1 when vY ≥ vX and vF=0 otherwise.
- R6: Sub-op 0x6 writes vX shifted right by one into vX and the old bit 0 into vF. Sub-op 0xE writes vX shifted left by one into vX and the old bit 7 into vF.
- R7: When an operation in R3 to R6 has x=15, vF afterwards holds only the flag value and the arithmetic result is discarded.
- R8: When x equals y, both operands are the same register. For example, XOR gives 0x00, and subtraction gives 0x00 with flag 1.
- R9: Class 1 (load-immediate) writes the immediate byte into vX. Class 2 (add-immediate) writes vX plus the immediate, modulo 256, into vX. Neither class changes vF unless x is 15.
- R10: Sub-ops 0x8 to 0xD and 0xF of class 0, and every operation of class 3, are illegal. They change no register and raise `op_illegal` together with `op_done` for one cycle.
- R11: An operation is accepted at a rising edge where `op_valid` and `op_ready` are both 1. `op_ready` is 0 for the next two cycles and `op_valid` is ignored during that time. `op_done` is 1 for exactly the third cycle after acceptance.
- R12: The result and the flag of one operation become visible together in the cycle where `op_done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation request |
| op_kind | input | 2 | Class: 0 reg-reg, 1 load-imm, 2 add-imm, 3 reserved |
| op_sub | input | 4 | Sub-operation code for class 0 |
| op_x | input | 4 | Destination and first operand index |
| op_y | input | 4 | Second operand index |
| op_imm | input | 8 | Immediate byte for classes 1 and 2 |
| dbg_idx | input | 4 | Debug read index |
| op_ready | output | 1 | High in ST_IDLE |
| op_done | output | 1 | One-cycle pulse after commit |
| op_illegal | output | 1 | One-cycle pulse with `op_done` for an illegal operation |
| dbg_data | output | 8 | Content of register `dbg_idx` (combinational) |

## Verification
The edge that accepts an operation is followed by two more edges. The commit happens on the second of them, so `op_done`, `op_illegal` and the new register values are all due in the third cycle after acceptance. The driver stamps each queued expectation with the cycle in which it raised `op_valid`. The monitor samples on falling clock edges, takes the front item when `op_done` is seen and requires the arrival to be exactly three cycles later. Only then does it sweep all sixteen registers through the debug port and compare them with the bench model. A request raised during ST_FETCH must leave no trace in that sweep.

// File: rtl/reg_alu_pkg.sv
`timescale 1ns/1ps
package reg_alu_pkg;

    typedef enum logic [1:0] {
        KIND_REGREG  = 2'd0,
        KIND_LOADIMM = 2'd1,
        KIND_ADDIMM  = 2'd2,
        KIND_RSVD    = 2'd3
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_COMMIT = 2'd2
    } ctrl_state_e;

    localparam logic [3:0] SUB_COPY = 4'h0;
    localparam logic [3:0] SUB_OR   = 4'h1;
    localparam logic [3:0] SUB_AND  = 4'h2;
    localparam logic [3:0] SUB_XOR  = 4'h3;
    localparam logic [3:0] SUB_ADD  = 4'h4;
    localparam logic [3:0] SUB_SUB  = 4'h5;
    localparam logic [3:0] SUB_SHR  = 4'h6;
    localparam logic [3:0] SUB_RSB  = 4'h7;
    localparam logic [3:0] SUB_SHL  = 4'hE;

endpackage

// File: rtl/reg_alu_ctrl.sv
`timescale 1ns/1ps
module reg_alu_ctrl
    import reg_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic illegal_in,
    output logic ready,
    output logic accept_en,
    output logic fetch_en,
    output logic commit_en,
    output logic done_q,
    output logic illegal_q
);

    ctrl_state_e state_q;
    ctrl_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (op_valid) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready     = (state_q == ST_IDLE);
        accept_en = (state_q == ST_IDLE) && op_valid;
        fetch_en  = (state_q == ST_FETCH);
        commit_en = (state_q == ST_COMMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= (state_q == ST_COMMIT);
            illegal_q <= (state_q == ST_COMMIT) && illegal_in;
        end
    end

endmodule

// File: rtl/reg_alu_exec.sv
`timescale 1ns/1ps
module reg_alu_exec
    import reg_alu_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int NREG   = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int FLAG_I = NREG - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        accept_en,
    input  logic                        fetch_en,
    input  logic                        commit_en,
    input  logic [1:0]                  op_kind,
    input  logic [3:0]                  op_sub,
    input  logic [IDX_W-1:0]            op_x,
    input  logic [IDX_W-1:0]            op_y,
    input  logic [DATA_W-1:0]           op_imm,
    input  logic [NREG-1:0][DATA_W-1:0] rf_q,
    output logic                        res_we,
    output logic [IDX_W-1:0]            res_idx,
    output logic [DATA_W-1:0]           res_data,
    output logic                        flg_we,
    output logic [DATA_W-1:0]           flg_data,
    output logic                        illegal,
    output op_kind_e                    kind_q
);

    logic [3:0]        sub_q;
    logic [IDX_W-1:0]  x_q;
    logic [IDX_W-1:0]  y_q;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;

    // operation fields are latched when the request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= KIND_REGREG;
            sub_q  <= '0;
            x_q    <= '0;
            y_q    <= '0;
            imm_q  <= '0;
        end else if (accept_en) begin
            kind_q <= op_kind_e'(op_kind);
            sub_q  <= op_sub;
            x_q    <= op_x;
            y_q    <= op_y;
            imm_q  <= op_imm;
        end
    end

    // operands are captured one cycle later; x == y reads one register twice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (fetch_en) begin
            a_q <= rf_q[x_q];
            b_q <= rf_q[y_q];
        end
    end

    logic [DATA_W:0]   sum_w;
    logic [DATA_W:0]   dif_xy;
    logic [DATA_W:0]   dif_yx;
    logic [DATA_W-1:0] imm_sum;

    always_comb begin
        sum_w   = {1'b0, a_q} + {1'b0, b_q};
        dif_xy  = {1'b0, a_q} - {1'b0, b_q};
        dif_yx  = {1'b0, b_q} - {1'b0, a_q};
        imm_sum = a_q + imm_q;
    end

    logic              wr_res;
    logic              wr_flg;
    logic [DATA_W-1:0] res_val;
    logic              flag_bit;
    logic              bad_op;

    always_comb begin
        wr_res   = 1'b0;
        wr_flg   = 1'b0;
        res_val  = '0;
        flag_bit = 1'b0;
        bad_op   = 1'b0;
        unique case (kind_q)
            KIND_REGREG: begin
                case (sub_q)
                    SUB_COPY: begin wr_res = 1'b1; res_val = b_q; end
                    SUB_OR:   begin wr_res = 1'b1; res_val = a_q | b_q; end
                    SUB_AND:  begin wr_res = 1'b1; res_val = a_q & b_q; end
                    SUB_XOR:  begin wr_res = 1'b1; res_val = a_q ^ b_q; end
                    SUB_ADD: begin
                        wr_res   = 1'b1;
                        wr_flg   = 1'b1;
                        res_val  = sum_w[DATA_W-1:0];
                        flag_bit = sum_w[DATA_W];
                    end
                    SUB_SUB: begin
                        wr_res   = 1'b1;
                        wr_flg   = 1'b1;
                        res_val  = dif_xy[DATA_W-1:0];
                        flag_bit = ~dif_xy[DATA_W];
                    end
                    SUB_RSB: begin
                        wr_res   = 1'b1;
                        wr_flg   = 1'b1;
                        res_val  = dif_yx[DATA_W-1:0];
                        flag_bit = ~dif_yx[DATA_W];
                    end
                    SUB_SHR: begin
                        wr_res   = 1'b1;
                        wr_flg   = 1'b1;
                        res_val  = {1'b0, a_q[DATA_W-1:1]};
                        flag_bit = a_q[0];
                    end
                    SUB_SHL: begin
                        wr_res   = 1'b1;
                        wr_flg   = 1'b1;
                        res_val  = {a_q[DATA_W-2:0], 1'b0};
                        flag_bit = a_q[DATA_W-1];
                    end
                    default: bad_op = 1'b1;
                endcase
            end
            KIND_LOADIMM: begin wr_res = 1'b1; res_val = imm_q; end
            KIND_ADDIMM:  begin wr_res = 1'b1; res_val = imm_sum; end
            KIND_RSVD:    bad_op = 1'b1;
            default:      bad_op = 1'b1;
        endcase
    end

    always_comb begin
        res_we   = commit_en && wr_res;
        res_idx  = x_q;
        res_data = res_val;
        flg_we   = commit_en && wr_flg;
        flg_data = {{(DATA_W-1){1'b0}}, flag_bit};
        illegal  = bad_op;
    end

endmodule

// File: rtl/reg_alu_regfile.sv
`timescale 1ns/1ps
module reg_alu_regfile #(
    parameter  int DATA_W = 8,
    parameter  int NREG   = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int FLAG_I = NREG - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        res_we,
    input  logic [IDX_W-1:0]            res_idx,
    input  logic [DATA_W-1:0]           res_data,
    input  logic                        flg_we,
    input  logic [DATA_W-1:0]           flg_data,
    output logic [NREG-1:0][DATA_W-1:0] rf_q
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == FLAG_I) begin : g_flag
            // flag port is checked first so it wins a collision on the flag register
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  rf_q[i] <= '0;
                else if (flg_we)                             rf_q[i] <= flg_data;
                else if (res_we && res_idx == IDX_W'(i))     rf_q[i] <= res_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                  rf_q[i] <= '0;
                else if (res_we && res_idx == IDX_W'(i))     rf_q[i] <= res_data;
            end
        end
    end

endmodule

// File: rtl/reg_alu_core.sv
`timescale 1ns/1ps
module reg_alu_core
    import reg_alu_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int NREG   = 16,
    localparam int IDX_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [3:0]        op_sub,
    input  logic [IDX_W-1:0]  op_x,
    input  logic [IDX_W-1:0]  op_y,
    input  logic [DATA_W-1:0] op_imm,
    input  logic [IDX_W-1:0]  dbg_idx,
    output logic              op_ready,
    output logic              op_done,
    output logic              op_illegal,
    output logic [DATA_W-1:0] dbg_data
);

    logic accept_en;
    logic fetch_en;
    logic commit_en;
    logic illegal;

    logic                        res_we;
    logic [IDX_W-1:0]            res_idx;
    logic [DATA_W-1:0]           res_data;
    logic                        flg_we;
    logic [DATA_W-1:0]           flg_data;
    logic [NREG-1:0][DATA_W-1:0] rf_q;
    op_kind_e                    kind_q;

    reg_alu_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .illegal_in (illegal),
        .ready      (op_ready),
        .accept_en  (accept_en),
        .fetch_en   (fetch_en),
        .commit_en  (commit_en),
        .done_q     (op_done),
        .illegal_q  (op_illegal)
    );

    reg_alu_exec #(.DATA_W(DATA_W), .NREG(NREG)) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_en (accept_en),
        .fetch_en  (fetch_en),
        .commit_en (commit_en),
        .op_kind   (op_kind),
        .op_sub    (op_sub),
        .op_x      (op_x),
        .op_y      (op_y),
        .op_imm    (op_imm),
        .rf_q      (rf_q),
        .res_we    (res_we),
        .res_idx   (res_idx),
        .res_data  (res_data),
        .flg_we    (flg_we),
        .flg_data  (flg_data),
        .illegal   (illegal),
        .kind_q    (kind_q)
    );

    reg_alu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .res_we   (res_we),
        .res_idx  (res_idx),
        .res_data (res_data),
        .flg_we   (flg_we),
        .flg_data (flg_data),
        .rf_q     (rf_q)
    );

    assign dbg_data = rf_q[dbg_idx];

endmodule

// File: rtl/reg_alu_core_chk.sv
`timescale 1ns/1ps
module reg_alu_core_chk
    import reg_alu_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int NREG   = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int FLAG_I = NREG - 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        op_valid,
    input logic                        op_ready,
    input logic                        op_done,
    input logic                        op_illegal,
    input logic                        res_we,
    input logic [IDX_W-1:0]            res_idx,
    input logic                        flg_we,
    input logic [DATA_W-1:0]           flg_data,
    input logic [NREG-1:0][DATA_W-1:0] rf_q,
    input op_kind_e                    kind_q
);

    // R10
    illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> op_done);

    // R10
    illegal_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> $stable(rf_q));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_ready);

    // R11
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(op_valid && op_ready, 3) |-> op_done);

    // R7
    flag_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && flg_we && res_idx == IDX_W'(FLAG_I)) |=> rf_q[FLAG_I] == $past(flg_data));

    // R9
    addimm_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && kind_q == KIND_ADDIMM && res_idx != IDX_W'(FLAG_I)) |=> $stable(rf_q[FLAG_I]));

endmodule

bind reg_alu_core reg_alu_core_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .op_done    (op_done),
    .op_illegal (op_illegal),
    .res_we     (res_we),
    .res_idx    (res_idx),
    .flg_we     (flg_we),
    .flg_data   (flg_data),
    .rf_q       (rf_q),
    .kind_q     (kind_q)
);

// File: tb/tb_reg_alu_core.sv
`timescale 1ns/1ps
module tb_reg_alu_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic [3:0] op_sub = 4'd0;
    logic [3:0] op_x = 4'd0;
    logic [3:0] op_y = 4'd0;
    logic [7:0] op_imm = 8'd0;
    logic [3:0] dbg_idx = 4'd0;
    logic       op_ready;
    logic       op_done;
    logic       op_illegal;
    logic [7:0] dbg_data;

    reg_alu_core dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_sub(op_sub), .op_x(op_x), .op_y(op_y), .op_imm(op_imm),
        .dbg_idx(dbg_idx), .op_ready(op_ready), .op_done(op_done),
        .op_illegal(op_illegal), .dbg_data(dbg_data)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        string    tag;
        bit       ill;
        logic [7:0] regs [16];
        int       issue;
    } exp_t;

    exp_t       sbq [$];
    logic [7:0] mdl [16];
    int         pending = 0;

    task automatic check(string tag, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [7:0] val);
        dbg_idx = 4'(idx);
        #0.1;
        val = dbg_data;
    endtask

    task automatic check_regs(string tag, logic [7:0] want [16]);
        logic [7:0] v;
        int bad_i = -1;
        logic [7:0] bad_got = 8'h00;
        for (int i = 0; i < 16; i++) begin
            read_reg(i, v);
            if (v !== want[i] && bad_i < 0) begin
                bad_i = i;
                bad_got = v;
            end
        end
        n_checks++;
        if (bad_i >= 0) begin
            n_fails++;
            $display("FAIL %s: reg v%0d got %0h expected %0h", tag, bad_i, bad_got, want[bad_i]);
        end
    endtask

    // bench model of the requirements
    task automatic model(input int kind, input int sub, input int x, input int y,
                         input int imm, output bit ill);
        int a = mdl[x];
        int b = mdl[y];
        int r = 0;
        int f = 0;
        bit wr_f = 1'b0;
        ill = 1'b0;
        if (kind == 1) r = imm;                                // R9
        else if (kind == 2) r = (a + imm) % 256;               // R9
        else if (kind == 3) ill = 1'b1;                        // R10
        else begin
            case (sub)
                0: r = b;                                      // R2
                1: r = a | b;
                2: r = a & b;
                3: r = a ^ b;
                4: begin r = (a + b) % 256; f = (a + b > 255) ? 1 : 0; wr_f = 1; end  // R3
                5: begin r = (a - b + 256) % 256; f = (a >= b) ? 1 : 0; wr_f = 1; end // R4
                7: begin r = (b - a + 256) % 256; f = (b >= a) ? 1 : 0; wr_f = 1; end // R5
                6: begin r = a / 2; f = a % 2; wr_f = 1; end                          // R6
                14: begin r = (a * 2) % 256; f = a / 128; wr_f = 1; end
                default: ill = 1'b1;
            endcase
        end
        if (!ill) begin
            mdl[x] = 8'(r);
            if (wr_f) mdl[15] = 8'(f);                         // R7: flag last
        end
    endtask

    task automatic wait_idle();
        while (pending != 0 || !op_ready) @(negedge clk);
    endtask

    task automatic do_op(string tag, int kind, int sub, int x, int y, int imm,
                         bit intrude = 1'b0);
        exp_t e;
        bit ill;
        wait_idle();
        model(kind, sub, x, y, imm, ill);
        e.tag = tag;
        e.ill = ill;
        e.regs = mdl;
        e.issue = cyc;
        sbq.push_back(e);
        pending++;
        op_kind = 2'(kind); op_sub = 4'(sub); op_x = 4'(x); op_y = 4'(y); op_imm = 8'(imm);
        op_valid = 1'b1;
        @(posedge clk); #1;
        op_valid = 1'b0;
        if (intrude) begin
            // R11: a request during the busy cycle must be dropped
            @(negedge clk);
            check("R11 ready low while busy", int'(op_ready), 0);
            op_kind = 2'd1; op_sub = 4'd0; op_x = 4'd1; op_y = 4'd0; op_imm = 8'hEE;
            op_valid = 1'b1;
            @(posedge clk); #1;
            op_valid = 1'b0;
        end
    endtask

    // monitor: pops expectations as results appear
    always @(negedge clk) begin
        if (rst_n && op_done && !finished) begin
            if (sbq.size() == 0) begin
                check("R11 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check({e.tag, " R11 done latency"}, cyc - e.issue, 3);
                check({e.tag, " R10 illegal flag"}, int'(op_illegal), int'(e.ill));
                check_regs({e.tag, " R12 register file"}, e.regs);
                pending--;
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready after reset", int'(op_ready), 1);
        check("R1 done after reset", int'(op_done), 0);
        check("R1 illegal after reset", int'(op_illegal), 0);
        check_regs("R1 registers cleared", mdl);

        // R9 load-immediate
        do_op("R9 ldi v1", 1, 0, 1, 0, 8'h3C);
        do_op("R9 ldi v2", 1, 0, 2, 0, 8'hA5);
        do_op("R9 ldi v3", 1, 0, 3, 0, 8'hFF);
        do_op("R9 ldi v4", 1, 0, 4, 0, 8'h01);
        do_op("R9 ldi v5", 1, 0, 5, 0, 8'h80);

        // R2 copy and logic
        do_op("R2 copy v6=v2", 0, 0, 6, 2, 0);
        do_op("R2 or v6|=v1", 0, 1, 6, 1, 0);
        do_op("R2 and v6&=v5", 0, 2, 6, 5, 0);
        do_op("R2 xor v1^=v2", 0, 3, 1, 2, 0);

        // R3 add with and without carry
        do_op("R3 ldi v7", 1, 0, 7, 0, 8'h10);
        do_op("R3 add no carry", 0, 4, 7, 4, 0);
        do_op("R3 add carry", 0, 4, 3, 4, 0);

        // R4 / R5 subtraction flags
        do_op("R4 ldi v8", 1, 0, 8, 0, 8'h3C);
        do_op("R4 sub borrow", 0, 5, 8, 2, 0);
        do_op("R4 ldi v9", 1, 0, 9, 0, 8'hA5);
        do_op("R4 ldi v10", 1, 0, 10, 0, 8'h3C);
        do_op("R4 sub no borrow", 0, 5, 9, 10, 0);
        do_op("R4 ldi v11", 1, 0, 11, 0, 8'h3C);
        do_op("R4 sub equal", 0, 5, 11, 10, 0);
        do_op("R5 rsb no borrow", 0, 7, 10, 2, 0);
        do_op("R5 rsb borrow", 0, 7, 2, 4, 0);

        // R6 shifts
        do_op("R6 shr odd", 0, 6, 4, 0, 0);
        do_op("R6 ldi v12", 1, 0, 12, 0, 8'hC2);
        do_op("R6 shr even", 0, 6, 12, 0, 0);
        do_op("R6 shl msb", 0, 14, 5, 0, 0);
        do_op("R6 ldi v13", 1, 0, 13, 0, 8'h41);
        do_op("R6 shl no msb", 0, 14, 13, 0, 0);

        // R7 destination vF keeps flag only
        do_op("R7 ldi vF", 1, 0, 15, 0, 8'hF0);
        do_op("R7 ldi v3", 1, 0, 3, 0, 8'h20);
        do_op("R7 add into vF", 0, 4, 15, 3, 0);
        do_op("R7 ldi vF big", 1, 0, 15, 0, 8'h7F);
        do_op("R7 shl into vF", 0, 14, 15, 0, 0);
        do_op("R7 ldi vF small", 1, 0, 15, 0, 8'h02);
        do_op("R7 sub into vF", 0, 5, 15, 3, 0);

        // R8 same register as both operands
        do_op("R8 ldi v2", 1, 0, 2, 0, 8'h5A);
        do_op("R8 xor self", 0, 3, 2, 2, 0);
        do_op("R8 ldi v3", 1, 0, 3, 0, 8'hFF);
        do_op("R8 add self", 0, 4, 3, 3, 0);
        do_op("R8 sub self", 0, 5, 3, 3, 0);

        // R9 add-immediate wraps and keeps vF
        do_op("R9 ldi vF", 1, 0, 15, 0, 8'h5A);
        do_op("R9 ldi v6", 1, 0, 6, 0, 8'hF0);
        do_op("R9 addi wrap", 2, 0, 6, 0, 8'h20);
        do_op("R9 addi plain", 2, 0, 6, 0, 8'h05);

        // R10 illegal codes
        do_op("R10 sub 8", 0, 8, 1, 2, 0);
        do_op("R10 sub D", 0, 13, 6, 6, 0);
        do_op("R10 sub F", 0, 15, 15, 3, 0);
        do_op("R10 class 3", 3, 4, 6, 3, 8'h11);

        // R11 request during busy is ignored
        do_op("R11 intruded op", 0, 0, 7, 6, 0, 1'b1);

        wait_idle();
        repeat (2) @(negedge clk);
        check("R11 queue empty", sbq.size(), 0);
        read_reg(1, v);
        check("R11 intruder left v1", int'(v), int'(mdl[1]));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule